// File: doc/BRIEF.md
# Filtered Uncore Event Counter

This block counts events reported by a shared agent, such as a cache slice or an interconnect node, for performance monitoring. Each cycle the agent can present one event beat. A beat carries an event code, the index of the core or thread that made the request, a request-type code, a data-source code, an 11-bit source cluster ID, an 11-bit target cluster ID and a one-bit ring channel flag. Software picks one event code and can switch on any mix of six qualifiers. These are a core bitmap, a request-type match, a data-source match, masked source and target ID matches, and a ring-channel selector.

A beat is counted only when its code matches the selected one and it passes every enabled qualifier. A qualifier that is switched off lets every beat through. The pass decision is registered and then added to a wrapping counter, which is `CNT_W` bits wide with a default of 48. When the counter wraps it sets a sticky overflow flag. Software reads and writes the registers through a single-cycle write port and a read port whose data is registered.

Top module: `uncore_evt_counter`

## Requirements
- R1: A beat with `evt_valid`=1 whose `evt_code` equals CTRL[7:0] and that passes every enabled qualifier raises the count by exactly one. The new value can be read two clock edges after the beat. A beat with `evt_valid`=0, or with any other code, leaves the count unchanged.
- R2: When CTRL[8] is set, a beat passes only if bit `evt_core` of the CORE_MAP register is set. For example, the map value 0x3 admits only requesters 0 and 1.
- R3: When CTRL[9] is set, a beat passes only if `evt_rtype` equals the REQ_TYPE register. The meaningful values are 3'b100 for read, 3'b101 for write, 3'b110 for atomic store and 3'b111 for atomic non-store.
- R4: A REQ_TYPE value with bit 2 clear is reserved. While CTRL[9] is set and REQ_TYPE holds a reserved value, no beat passes and the count holds.
- R5: When CTRL[10] is set, a beat passes only if its 5-bit `evt_dsrc` equals the DSRC register. Examples are 5'b01110 for local DRAM, 5'b01111 for cross-die DRAM and 5'b00001 for a cache on the same die.
- R6: The source match is enabled by CTRL[11] and the target match by CTRL[12]. Each of the SRC_MATCH and DST_MATCH registers holds a command value in [10:0] and a mask in [26:16]. A set mask bit excludes that ID bit from the comparison. A beat passes when every unmasked ID bit equals the command value. An ID is made of a 6-bit die ID in bits [10:5] and a 5-bit cluster ID in bits [4:0].
- R7: The channel qualifier is enabled by CTRL[13] and configured by the CHAN register [1:0]. It acts only on event codes 0x47 through 0x59 inclusive.
  - A value of 2'b01 or 2'b11 admits only beats with `evt_chan`=1 (extended ring).
  - A value of 2'b10 admits only beats with `evt_chan`=0.
  - A value of 2'b00 admits both.
  - For any other event code the channel qualifier has no effect.
- R8: A qualifier whose enable bit is clear passes every beat, whatever its configuration register holds. With all enables clear, every valid beat carrying the selected code is counted.
- R9: A write of any value to address 7 zeroes the counter on that clock edge. If an increment falls on the same edge, the clear wins.
- R10: The counter wraps from all ones to zero. The wrap sets `ovf_flag`, which also reads as STATUS[0] at address 9. The flag stays set until a write to address 9 with data bit 0 set. A write with bit 0 clear leaves the flag set.
- R11: The register addresses are CTRL=0, CORE_MAP=1, REQ_TYPE=2, DSRC=3, SRC_MATCH=4, DST_MATCH=5, CHAN=6, CNT_LO=7, CNT_HI=8 and STATUS=9.
  - After reset all configuration registers read 0.
  - A read with `cfg_rd_en` returns data and `cfg_rd_valid` one cycle later.
  - A configuration write applies to beats from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Event beat present this cycle |
| evt_code | input | 8 | Event code of the beat |
| evt_core | input | $clog2(NCORE) | Requesting core/thread index |
| evt_rtype | input | 3 | Request-type code |
| evt_dsrc | input | 5 | Data-source code |
| evt_src_id | input | 11 | Source cluster ID |
| evt_dst_id | input | 11 | Target cluster ID |
| evt_chan | input | 1 | 1 = extended ring channel, 0 = normal ring |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for write or read |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_rd_data | output | 32 | Registered read data |
| cfg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
Each qualifier is exercised in turn with a batch of beats in which some beats should pass and some should fail. Comparing the resulting count against the number of passing beats shows whether the qualifier admits exactly the intended values. Further batches probe the boundary cases:
- reserved request types;
- mask bits that hide the low cluster ID;
- channel codes at both ends of the 0x47–0x59 window and just outside it;
- restrictive configurations left in place with the enables cleared.

A clear timed to land on the same edge as an increment separates clear priority from plain clearing. A run to the counter's top value and one beat past it separates the wrap, the sticky flag and write-one-to-clear from one another.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int CODE_W = 8;
   localparam int TYPE_W = 3;
   localparam int DSRC_W = 5;
   localparam int ID_W   = 11;
   localparam int CHAN_W = 2;
   localparam int REG_AW = 4;
   localparam int REG_DW = 32;
   localparam int N_QUAL = 6;

   // qualifier enable positions (CTRL bit = CODE_W + index)
   localparam int Q_CORE = 0;
   localparam int Q_TYPE = 1;
   localparam int Q_DSRC = 2;
   localparam int Q_SRC  = 3;
   localparam int Q_DST  = 4;
   localparam int Q_CHAN = 5;

   localparam logic [REG_AW-1:0] A_CTRL  = 4'd0;
   localparam logic [REG_AW-1:0] A_CMAP  = 4'd1;
   localparam logic [REG_AW-1:0] A_RTYPE = 4'd2;
   localparam logic [REG_AW-1:0] A_DSRC  = 4'd3;
   localparam logic [REG_AW-1:0] A_SRC   = 4'd4;
   localparam logic [REG_AW-1:0] A_DST   = 4'd5;
   localparam logic [REG_AW-1:0] A_CHAN  = 4'd6;
   localparam logic [REG_AW-1:0] A_CNTL  = 4'd7;
   localparam logic [REG_AW-1:0] A_CNTH  = 4'd8;
   localparam logic [REG_AW-1:0] A_STAT  = 4'd9;

   localparam logic [CODE_W-1:0] CHAN_CODE_LO = 8'h47;
   localparam logic [CODE_W-1:0] CHAN_CODE_HI = 8'h59;

   localparam int MSK_LSB = 16;

   typedef struct packed {
      logic [N_QUAL-1:0]  en;
      logic [CODE_W-1:0]  code;
      logic [TYPE_W-1:0]  rtype;
      logic [DSRC_W-1:0]  dsrc;
      logic [ID_W-1:0]    src_cmd;
      logic [ID_W-1:0]    src_msk;
      logic [ID_W-1:0]    dst_cmd;
      logic [ID_W-1:0]    dst_msk;
      logic [CHAN_W-1:0]  chan;
   } pmu_cfg_t;
endpackage

// File: rtl/pmu_cfg_regs.sv
module pmu_cfg_regs
   import pmu_pkg::*;
#(
   parameter int NCORE = 8,
   parameter int CNT_W = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_AW-1:0]    addr,
   input  logic [REG_DW-1:0]    wr_data,
   input  logic                 rd_en,
   input  logic [CNT_W-1:0]     cnt,
   input  logic                 ovf,
   output pmu_cfg_t             cfg,
   output logic [NCORE-1:0]     core_map,
   output logic [REG_DW-1:0]    rd_data,
   output logic                 rd_valid,
   output logic                 clr_cnt,
   output logic                 clr_ovf
);
   logic [REG_DW-1:0] cnt_lo, cnt_hi, rd_d;

   generate
      if (CNT_W > REG_DW) begin : g_wide
         assign cnt_lo = cnt[REG_DW-1:0];
         assign cnt_hi = REG_DW'(cnt[CNT_W-1:REG_DW]);
      end else begin : g_narrow
         assign cnt_lo = REG_DW'(cnt);
         assign cnt_hi = '0;
      end
   endgenerate

   assign clr_cnt = wr_en && (addr == A_CNTL);
   assign clr_ovf = wr_en && (addr == A_STAT) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '0;
         core_map <= '0;
      end else if (wr_en) begin
         case (addr)
            A_CTRL: begin
               cfg.code <= wr_data[CODE_W-1:0];
               cfg.en   <= wr_data[CODE_W +: N_QUAL];
            end
            A_CMAP:  core_map  <= wr_data[NCORE-1:0];
            A_RTYPE: cfg.rtype <= wr_data[TYPE_W-1:0];
            A_DSRC:  cfg.dsrc  <= wr_data[DSRC_W-1:0];
            A_SRC: begin
               cfg.src_cmd <= wr_data[ID_W-1:0];
               cfg.src_msk <= wr_data[MSK_LSB +: ID_W];
            end
            A_DST: begin
               cfg.dst_cmd <= wr_data[ID_W-1:0];
               cfg.dst_msk <= wr_data[MSK_LSB +: ID_W];
            end
            A_CHAN:  cfg.chan  <= wr_data[CHAN_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_d = '0;
      case (addr)
         A_CTRL:  rd_d = REG_DW'({cfg.en, cfg.code});
         A_CMAP:  rd_d = REG_DW'(core_map);
         A_RTYPE: rd_d = REG_DW'(cfg.rtype);
         A_DSRC:  rd_d = REG_DW'(cfg.dsrc);
         A_SRC:   rd_d = REG_DW'({cfg.src_msk, 5'b0, cfg.src_cmd});
         A_DST:   rd_d = REG_DW'({cfg.dst_msk, 5'b0, cfg.dst_cmd});
         A_CHAN:  rd_d = REG_DW'(cfg.chan);
         A_CNTL:  rd_d = cnt_lo;
         A_CNTH:  rd_d = cnt_hi;
         A_STAT:  rd_d = REG_DW'(ovf);
         default: rd_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rd_d;
      end
   end

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R11
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid); // R11
endmodule

// File: rtl/pmu_evt_filter.sv
module pmu_evt_filter
   import pmu_pkg::*;
#(
   parameter int NCORE = 8,
   localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
   input  logic               valid,
   input  logic [CODE_W-1:0]  code,
   input  logic [IDX_W-1:0]   core,
   input  logic [TYPE_W-1:0]  rtype,
   input  logic [DSRC_W-1:0]  dsrc,
   input  logic [ID_W-1:0]    src_id,
   input  logic [ID_W-1:0]    dst_id,
   input  logic               chan,
   input  pmu_cfg_t           cfg,
   input  logic [NCORE-1:0]   core_map,
   output logic               hit
);
   logic [N_QUAL-1:0] q_ok;
   logic              code_ok, chan_window, chan_sel;
   logic [1:0][ID_W-1:0] ids, cmds, msks;

   assign code_ok = valid && (code == cfg.code);

   assign q_ok[Q_CORE] = !cfg.en[Q_CORE] || core_map[core];
   assign q_ok[Q_TYPE] = !cfg.en[Q_TYPE] ||
                         (cfg.rtype[TYPE_W-1] && (rtype == cfg.rtype));
   assign q_ok[Q_DSRC] = !cfg.en[Q_DSRC] || (dsrc == cfg.dsrc);

   assign ids  = {dst_id, src_id};
   assign cmds = {cfg.dst_cmd, cfg.src_cmd};
   assign msks = {cfg.dst_msk, cfg.src_msk};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_idm
         localparam int QI = (g == 0) ? Q_SRC : Q_DST;
         assign q_ok[QI] = !cfg.en[QI] ||
                           (((ids[g] ^ cmds[g]) & ~msks[g]) == '0);
      end
   endgenerate

   assign chan_window = (code >= CHAN_CODE_LO) && (code <= CHAN_CODE_HI);
   always_comb begin
      case (cfg.chan)
         2'b00:   chan_sel = 1'b1;
         2'b10:   chan_sel = !chan;
         default: chan_sel = chan;
      endcase
   end
   assign q_ok[Q_CHAN] = !cfg.en[Q_CHAN] || !chan_window || chan_sel;

   assign hit = code_ok && (&q_ok);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CNT_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic             clr_ovf,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   logic wrap;
   assign wrap = inc && !clr && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (inc)    cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (wrap)    ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
   end

   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt)); // R1
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0); // R9
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && (&cnt)) |=> (ovf && cnt == '0)); // R10
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf); // R10
endmodule

// File: rtl/uncore_evt_counter.sv
module uncore_evt_counter
   import pmu_pkg::*;
#(
   parameter int NCORE = 8,
   parameter int CNT_W = 48,
   localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_valid,
   input  logic [CODE_W-1:0]  evt_code,
   input  logic [IDX_W-1:0]   evt_core,
   input  logic [TYPE_W-1:0]  evt_rtype,
   input  logic [DSRC_W-1:0]  evt_dsrc,
   input  logic [ID_W-1:0]    evt_src_id,
   input  logic [ID_W-1:0]    evt_dst_id,
   input  logic               evt_chan,
   input  logic               cfg_wr_en,
   input  logic [REG_AW-1:0]  cfg_addr,
   input  logic [REG_DW-1:0]  cfg_wr_data,
   input  logic               cfg_rd_en,
   output logic [REG_DW-1:0]  cfg_rd_data,
   output logic               cfg_rd_valid,
   output logic               ovf_flag
);
   generate
      if (NCORE < 2 || NCORE > REG_DW || (1 << IDX_W) != NCORE) begin : g_bad_ncore
         $error("NCORE must be a power of two between 2 and 32");
      end
      if (CNT_W < 8 || CNT_W > 2 * REG_DW) begin : g_bad_cntw
         $error("CNT_W must lie between 8 and 64");
      end
   endgenerate

   pmu_cfg_t         cfg;
   logic [NCORE-1:0] core_map;
   logic [CNT_W-1:0] cnt;
   logic             hit, hit_q, clr_cnt, clr_ovf;

   pmu_cfg_regs #(.NCORE(NCORE), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .addr(cfg_addr), .wr_data(cfg_wr_data),
      .rd_en(cfg_rd_en), .cnt(cnt), .ovf(ovf_flag),
      .cfg(cfg), .core_map(core_map),
      .rd_data(cfg_rd_data), .rd_valid(cfg_rd_valid),
      .clr_cnt(clr_cnt), .clr_ovf(clr_ovf)
   );

   pmu_evt_filter #(.NCORE(NCORE)) u_filt (
      .valid(evt_valid), .code(evt_code), .core(evt_core),
      .rtype(evt_rtype), .dsrc(evt_dsrc),
      .src_id(evt_src_id), .dst_id(evt_dst_id), .chan(evt_chan),
      .cfg(cfg), .core_map(core_map), .hit(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= hit;
   end

   pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(hit_q), .clr(clr_cnt), .clr_ovf(clr_ovf),
      .cnt(cnt), .ovf(ovf_flag)
   );

   AST_NO_CODE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_valid && evt_code == cfg.code) |=> !hit_q); // R1
   AST_RSVD_TYPE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en[Q_TYPE] && !cfg.rtype[TYPE_W-1]) |=> !hit_q); // R4
   AST_CORE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en[Q_CORE] && !core_map[evt_core]) |=> !hit_q); // R2
endmodule

// File: tb/tb_uncore_evt_counter.sv
module tb_uncore_evt_counter;
   localparam int CLK_PERIOD = 10;
   localparam int NCORE = 8;
   localparam int CNT_W = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [7:0]  evt_code = '0;
   logic [2:0]  evt_core = '0;
   logic [2:0]  evt_rtype = '0;
   logic [4:0]  evt_dsrc = '0;
   logic [10:0] evt_src_id = '0;
   logic [10:0] evt_dst_id = '0;
   logic        evt_chan = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        cfg_rd_en = 1'b0;
   logic [31:0] cfg_rd_data;
   logic        cfg_rd_valid;
   logic        ovf_flag;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   uncore_evt_counter #(.NCORE(NCORE), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(evt_valid), .evt_code(evt_code), .evt_core(evt_core),
      .evt_rtype(evt_rtype), .evt_dsrc(evt_dsrc),
      .evt_src_id(evt_src_id), .evt_dst_id(evt_dst_id), .evt_chan(evt_chan),
      .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_en(cfg_rd_en), .cfg_rd_data(cfg_rd_data),
      .cfg_rd_valid(cfg_rd_valid), .ovf_flag(ovf_flag)
   );

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && cfg_rd_valid) begin
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R11: unexpected read data %h, expected no read", cfg_rd_data);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (cfg_rd_data !== e) begin
               n_fail++;
               $display("FAIL %s: read %h expected %h", t, cfg_rd_data, e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      finish_run();
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      cfg_rd_en = 1'b1; cfg_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      cfg_rd_en = 1'b0;
   endtask

   task automatic beat(input logic [7:0] c, input logic [2:0] ix, input logic [2:0] t,
                       input logic [4:0] d, input logic [10:0] s, input logic [10:0] g,
                       input logic ch, input logic v, input int n);
      @(negedge clk);
      evt_valid = v; evt_code = c; evt_core = ix; evt_rtype = t;
      evt_dsrc = d; evt_src_id = s; evt_dst_id = g; evt_chan = ch;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic b(input logic [7:0] c);
      beat(c, 3'd0, 3'b100, 5'b00001, 11'h0, 11'h0, 1'b0, 1'b1, 1);
   endtask

   task automatic chk_cnt(input logic [31:0] e, input string t);
      idle(2);
      rd(4'd7, e, t);
      wr(4'd7, 32'h0);
   endtask

   task automatic chk_bit(input logic a, input logic e, input string t);
      n_checks++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", t, a, e);
      end
   endtask

   function automatic logic [31:0] ctrl(input logic [7:0] c, input logic [5:0] en);
      return {18'b0, en, c};
   endfunction

   initial begin
      idle(3);
      rst_n = 1'b1;
      // reset state
      chk_bit(ovf_flag, 1'b0, "R10 reset ovf");
      rd(4'd0, 32'h0, "R11 reset CTRL");
      rd(4'd7, 32'h0, "R11 reset count");
      rd(4'd9, 32'h0, "R10 reset status");

      // R1 plain event-code match
      wr(4'd0, ctrl(8'h10, 6'b0));
      b(8'h10); b(8'h10); b(8'h10); b(8'h11);
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b0, 1);
      chk_cnt(32'd3, "R1 code match");

      // R2 core bitmap
      wr(4'd1, 32'h3);
      wr(4'd0, ctrl(8'h10, 6'b000001));
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd1, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd2, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd5, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      chk_cnt(32'd2, "R2 core map 0x3");

      // R3 request type write
      wr(4'd2, 32'h5);
      wr(4'd0, ctrl(8'h10, 6'b000010));
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd0, 3'b101, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 2);
      beat(8'h10, 3'd0, 3'b111, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      chk_cnt(32'd2, "R3 type write");

      // R4 reserved type
      wr(4'd2, 32'h2);
      beat(8'h10, 3'd0, 3'b010, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      chk_cnt(32'd0, "R4 reserved type");

      // R5 data source
      wr(4'd3, 32'h0E);
      wr(4'd0, ctrl(8'h10, 6'b000100));
      beat(8'h10, 3'd0, 3'b100, 5'b01110, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd0, 3'b100, 5'b01111, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd0, 3'b100, 5'b00001, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      chk_cnt(32'd1, "R5 dsrc local DRAM");

      // R6 masked source match: die 3, any cluster
      wr(4'd4, (32'h1F << 16) | 32'h060);
      rd(4'd4, (32'h1F << 16) | 32'h060, "R11 SRC readback");
      wr(4'd0, ctrl(8'h10, 6'b001000));
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h061, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h070, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h081, 11'h0, 1'b0, 1'b1, 1);
      chk_cnt(32'd2, "R6 src masked");
      // R6 exact target match
      wr(4'd5, 32'h030);
      wr(4'd0, ctrl(8'h10, 6'b010000));
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h0, 11'h030, 1'b0, 1'b1, 1);
      beat(8'h10, 3'd0, 3'b100, 5'd1, 11'h0, 11'h031, 1'b0, 1'b1, 1);
      chk_cnt(32'd1, "R6 dst exact");

      // R7 channel qualifier
      wr(4'd6, 32'h2);
      wr(4'd0, ctrl(8'h50, 6'b100000));
      beat(8'h50, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 2);
      beat(8'h50, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b1, 1'b1, 1);
      chk_cnt(32'd2, "R7 chan 10 normal only");
      wr(4'd6, 32'h1);
      beat(8'h50, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h50, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b1, 1'b1, 1);
      chk_cnt(32'd1, "R7 chan 01 extended only");
      wr(4'd6, 32'h3);
      wr(4'd0, ctrl(8'h59, 6'b100000));
      beat(8'h59, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      chk_cnt(32'd0, "R7 code 0x59 in window");
      wr(4'd0, ctrl(8'h47, 6'b100000));
      beat(8'h47, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b1, 1'b1, 1);
      chk_cnt(32'd1, "R7 code 0x47 extended");
      wr(4'd0, ctrl(8'h5A, 6'b100000));
      beat(8'h5A, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      chk_cnt(32'd1, "R7 code 0x5A ignored");
      wr(4'd6, 32'h0);
      wr(4'd0, ctrl(8'h50, 6'b100000));
      beat(8'h50, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, 1);
      beat(8'h50, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b1, 1'b1, 1);
      chk_cnt(32'd2, "R7 chan 00 both");

      // R8 restrictive settings, all enables off
      wr(4'd2, 32'h2);
      wr(4'd6, 32'h2);
      wr(4'd0, ctrl(8'h50, 6'b0));
      rd(4'd0, 32'h50, "R11 CTRL readback");
      beat(8'h50, 3'd5, 3'b111, 5'b00001, 11'h7FF, 11'h7FF, 1'b1, 1'b1, 3);
      chk_cnt(32'd3, "R8 disabled qualifiers pass");

      // R9 clear on the same edge as an increment
      b(8'h50); b(8'h50);
      @(negedge clk);
      evt_valid = 1'b1; evt_code = 8'h50;
      @(negedge clk);
      evt_valid = 1'b0;
      cfg_wr_en = 1'b1; cfg_addr = 4'd7; cfg_wr_data = 32'h0;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      idle(2);
      rd(4'd7, 32'd0, "R9 clear beats increment");

      // R10 wrap and sticky overflow
      wr(4'd7, 32'h0);
      beat(8'h50, 3'd0, 3'b100, 5'd1, 11'h0, 11'h0, 1'b0, 1'b1, (1 << CNT_W) - 1);
      idle(2);
      rd(4'd7, (1 << CNT_W) - 1, "R10 at top value");
      chk_bit(ovf_flag, 1'b0, "R10 no ovf before wrap");
      b(8'h50);
      idle(2);
      chk_bit(ovf_flag, 1'b1, "R10 ovf on wrap");
      rd(4'd7, 32'd0, "R10 wrapped to zero");
      b(8'h50);
      idle(2);
      rd(4'd7, 32'd1, "R10 counts after wrap");
      chk_bit(ovf_flag, 1'b1, "R10 ovf sticky");
      wr(4'd9, 32'h0);
      chk_bit(ovf_flag, 1'b1, "R10 write 0 keeps ovf");
      wr(4'd9, 32'h1);
      chk_bit(ovf_flag, 1'b0, "R10 write 1 clears ovf");
      rd(4'd9, 32'h0, "R10 status cleared");

      idle(4);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule